// File: doc/BRIEF.md
# Scan Test Sequencing Controller

This block runs the stepping of a scan test over an on-chip scan chain. After a start request it loads one pattern by shifting for a programmed number of cycles, then holds a one-cycle apply window, then gives one capture cycle. It repeats this for a programmed number of patterns. A final shift pass unloads the last captured response, and then the block signals completion. The response of each pattern leaves the chain during the shift pass that loads the next pattern.

Four separate scan enables come out of the block, so that each can be routed on its own net: one for the chain multiplexers, one holding tristate bus drivers in a safe state, one steering pins borrowed for scan data, and one forcing logic into a safe state. All four are decoded from registered state, so each one changes only just after a rising clock edge and is stable through the low half of the cycle. Per-domain capture enables let exactly one clock domain pulse in each capture cycle. The chosen domain rotates among the enabled domains. Serial scan data passes between the tester side and the chain only while shifting.

Top module: `scan_seq_ctrl`

## Requirements
- R1: Out of reset, and whenever no run is active, busy, done, pi_apply, all four scan enables and every cap_en bit are low.
- R2: A start seen in idle latches cfg_len, cfg_pats and cfg_dom_en and raises busy on the next cycle. A start during a run, and any change of the cfg inputs during a run, have no effect on that run.
- R3: Each shift pass holds se_shift, se_bus, se_brw and se_force high for exactly L consecutive cycles, where L is the latched length. A length of 0 is treated as 1. The first busy cycle is a shift cycle.
- R4: After each loading shift pass comes exactly one apply cycle: pi_apply high, all scan enables low, cap_en all zero.
- R5: The apply cycle is followed by exactly one capture cycle. In it pi_apply stays high, all scan enables are low, and at most one cap_en bit is high. Shifting resumes on the next cycle, which unloads the response while loading the next pattern.
- R6: Capture domains rotate. The first capture of a run uses the lowest-numbered enabled domain. Each later capture uses the next enabled domain of higher index, wrapping to index 0. With an empty domain mask no cap_en bit is ever raised, and the timing is otherwise unchanged.
- R7: With a latched pattern count P, a run makes P captures and then one more unload-only shift pass of L cycles. The run lasts P*(L+2)+L busy cycles. P = 0 gives just the single unload pass.
- R8: done is high for exactly one cycle, the cycle right after the final shift pass. In that cycle busy is low and all enables are low. The block is idle on the following cycle.
- R9: While se_shift is high, chain_sdi follows tst_sdi and tst_sdo follows chain_sdo in the same cycle. While se_shift is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, taken only in idle |
| cfg_len | input | LEN_W | Chain length in shift cycles |
| cfg_pats | input | PAT_W | Number of patterns |
| cfg_dom_en | input | NDOM | Mask of domains allowed to capture |
| tst_sdi | input | 1 | Serial scan data from tester |
| tst_sdo | output | 1 | Serial scan data to tester |
| chain_sdi | output | 1 | Serial data into the chain |
| chain_sdo | input | 1 | Serial data out of the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| se_shift | output | 1 | Chain multiplexer shift enable |
| se_bus | output | 1 | Tristate bus safe-state enable |
| se_brw | output | 1 | Borrowed scan pin steering enable |
| se_force | output | 1 | Logic forcing enable |
| pi_apply | output | 1 | Primary input apply window |
| cap_en | output | NDOM | Per-domain capture clock enables |

## Verification
The bench uses the default parameters: an 8-bit length, a 6-bit pattern count and three clock domains. Three domains are enough to show the rotation wrapping and skipping a disabled domain with masks such as 101 and 110, as well as the single-domain and empty-mask cases. Small lengths, including 0 and 1, together with pattern counts from 0 to 4, reach every phase boundary within a few dozen cycles per run. The model of each cycle is compared on every cycle of every run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SHIFT = 3'd1,
    PH_APPLY = 3'd2,
    PH_CAPT  = 3'd3,
    PH_FIN   = 3'd4
  } phase_e;
endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [PAT_W-1:0] cfg_pats,
  output phase_e           phase,
  output logic             load
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [PAT_W-1:0] PAT_ONE = PAT_W'(1);

  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] len_q, len_d, cnt_q, cnt_d;
  logic [PAT_W-1:0] pats_q, pats_d, pat_q, pat_d;
  logic             cfg_en, cnt_en, pat_en;
  logic             last_shift;

  assign last_shift = (cnt_q == len_q - LEN_ONE);
  assign load       = (ph_q == PH_IDLE) && start;
  assign phase      = ph_q;

  always_comb begin
    ph_d   = ph_q;
    len_d  = len_q;
    pats_d = pats_q;
    cnt_d  = cnt_q;
    pat_d  = pat_q;
    cfg_en = 1'b0;
    cnt_en = 1'b0;
    pat_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_SHIFT;
          cfg_en = 1'b1;
          len_d  = (cfg_len == '0) ? LEN_ONE : cfg_len;
          pats_d = cfg_pats;
          cnt_en = 1'b1;
          cnt_d  = '0;
          pat_en = 1'b1;
          pat_d  = '0;
        end
      end
      PH_SHIFT: begin
        cnt_en = 1'b1;
        if (last_shift) begin
          cnt_d = '0;
          ph_d  = (pat_q == pats_q) ? PH_FIN : PH_APPLY;
        end else begin
          cnt_d = cnt_q + LEN_ONE;
        end
      end
      PH_APPLY: ph_d = PH_CAPT;
      PH_CAPT: begin
        ph_d   = PH_SHIFT;
        pat_en = 1'b1;
        pat_d  = pat_q + PAT_ONE;
      end
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_ONE;
      pats_q <= '0;
    end else if (cfg_en) begin
      len_q  <= len_d;
      pats_q <= pats_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (pat_en) begin
      pat_q <= pat_d;
    end
  end
endmodule

// File: rtl/scan_dom_rr.sv
module scan_dom_rr #(
  parameter int NDOM  = 3,
  parameter int IDX_W = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NDOM-1:0]  cfg_mask,
  input  logic             adv,
  output logic [NDOM-1:0]  mask,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NDOM - 1);

  logic [NDOM-1:0]  mask_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] cur,
                                               input logic [NDOM-1:0]  m);
    logic [IDX_W-1:0] res;
    logic             hit;
    int               c;
    res = cur;
    hit = 1'b0;
    for (int i = 1; i <= NDOM; i++) begin
      c = (int'(cur) + i) % NDOM;
      if (!hit && m[c]) begin
        res = IDX_W'(c);
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    idx_en = load | adv;
    idx_d  = load ? rr_next(IDX_TOP, cfg_mask) : rr_next(idx_q, mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= cfg_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign mask = mask_q;
  assign idx  = idx_q;
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 6,
  parameter int NDOM  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [PAT_W-1:0] cfg_pats,
  input  logic [NDOM-1:0]  cfg_dom_en,
  input  logic             tst_sdi,
  output logic             tst_sdo,
  output logic             chain_sdi,
  input  logic             chain_sdo,
  output logic             busy,
  output logic             done,
  output logic             se_shift,
  output logic             se_bus,
  output logic             se_brw,
  output logic             se_force,
  output logic             pi_apply,
  output logic [NDOM-1:0]  cap_en
);
  localparam int IDX_W = (NDOM > 1) ? $clog2(NDOM) : 1;

  phase_e           phase;
  logic             load;
  logic [NDOM-1:0]  mask;
  logic [IDX_W-1:0] idx;
  logic             shifting, capturing;

  scan_seq_fsm #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_len  (cfg_len),
    .cfg_pats (cfg_pats),
    .phase    (phase),
    .load     (load)
  );

  scan_dom_rr #(.NDOM(NDOM), .IDX_W(IDX_W)) u_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cfg_mask (cfg_dom_en),
    .adv      (capturing),
    .mask     (mask),
    .idx      (idx)
  );

  assign shifting  = (phase == PH_SHIFT);
  assign capturing = (phase == PH_CAPT);

  assign busy     = shifting | capturing | (phase == PH_APPLY);
  assign done     = (phase == PH_FIN);
  assign pi_apply = capturing | (phase == PH_APPLY);
  assign se_shift = shifting;
  assign se_bus   = shifting;
  assign se_brw   = shifting;
  assign se_force = shifting;

  assign chain_sdi = shifting & tst_sdi;
  assign tst_sdo   = shifting & chain_sdo;

  for (genvar g = 0; g < NDOM; g++) begin : g_cap
    assign cap_en[g] = capturing & mask[g] & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NDOM = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            se_shift,
  input logic            se_bus,
  input logic            pi_apply,
  input logic [NDOM-1:0] cap_en
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!se_shift && !se_bus && cap_en == '0)); // R1

  AST_FIRST_BUSY_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> se_shift); // R3

  AST_CAP_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_en) |-> ($past(pi_apply) && !se_shift && !se_bus)); // R4

  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en)); // R5

  AST_CAP_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_en) |=> se_shift); // R5

  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(se_shift) && !busy)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind scan_seq_ctrl scan_seq_chk #(.NDOM(NDOM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .se_shift (se_shift),
  .se_bus   (se_bus),
  .pi_apply (pi_apply),
  .cap_en   (cap_en)
);

// File: tb/scan_seq_ctrl_bench.sv
`timescale 1ns/100ps
module scan_seq_ctrl_bench;
  localparam int LEN_W = 8;
  localparam int PAT_W = 6;
  localparam int NDOM  = 3;

  typedef struct packed {
    logic [7:0]  len;
    logic [5:0]  pats;
    logic [2:0]  mask;
    logic [15:0] exp_busy;
  } cfg_t;

  localparam int NCFG = 6;
  localparam cfg_t TBL [NCFG] = '{
    '{8'd4, 6'd2, 3'b111, 16'd16},
    '{8'd1, 6'd3, 3'b101, 16'd10},
    '{8'd0, 6'd1, 3'b010, 16'd4},
    '{8'd5, 6'd0, 3'b111, 16'd5},
    '{8'd3, 6'd4, 3'b000, 16'd23},
    '{8'd2, 6'd4, 3'b110, 16'd18}
  };

  logic clk, rst_n, start;
  logic [LEN_W-1:0] cfg_len;
  logic [PAT_W-1:0] cfg_pats;
  logic [NDOM-1:0]  cfg_dom_en;
  logic tst_sdi, tst_sdo, chain_sdi, chain_sdo;
  logic busy, done, se_shift, se_bus, se_brw, se_force, pi_apply;
  logic [NDOM-1:0] cap_en;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  scan_seq_ctrl #(.LEN_W(LEN_W), .PAT_W(PAT_W), .NDOM(NDOM)) u_scan_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_pats(cfg_pats), .cfg_dom_en(cfg_dom_en), .tst_sdi(tst_sdi),
    .tst_sdo(tst_sdo), .chain_sdi(chain_sdi), .chain_sdo(chain_sdo),
    .busy(busy), .done(done), .se_shift(se_shift), .se_bus(se_bus),
    .se_brw(se_brw), .se_force(se_force), .pi_apply(pi_apply), .cap_en(cap_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int cyc,
                     input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, got, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {busy, done, se_shift, se_bus, se_brw, se_force, pi_apply, cap_en};
  endfunction

  task automatic run_cfg(input logic [7:0] l, input logic [5:0] p,
                         input logic [2:0] m, input int exp_busy, input bit poke);
    int lr, per, last, nbusy, cur;
    logic [9:0] exp;
    logic [2:0] cexp;
    string tag;
    lr    = (l == 0) ? 1 : int'(l);
    per   = lr + 2;
    last  = int'(p) * per + lr;
    nbusy = 0;
    cur   = NDOM - 1;
    @(negedge clk);
    cfg_len = l; cfg_pats = p; cfg_dom_en = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= last; t++) begin
      if (poke && t == 2) begin
        start = 1'b1; cfg_len = 8'd9; cfg_pats = 6'd7; cfg_dom_en = 3'b000;
      end
      if (poke && t == 3) start = 1'b0;
      tst_sdi   = t[0];
      chain_sdo = ~t[1];
      #0.5;
      cexp = 3'b000;
      if (t < int'(p) * per) begin
        if (t % per < lr) begin
          exp = 10'b1011110000; tag = "R3";
        end else if (t % per == lr) begin
          exp = 10'b1000001000; tag = "R4";
        end else begin
          if (m != 3'b000) begin
            for (int i = 1; i <= NDOM; i++) begin
              if (m[(cur + i) % NDOM]) begin
                cur = (cur + i) % NDOM;
                break;
              end
            end
            cexp = 3'b001 << cur;
          end
          exp = {7'b1000001, cexp}; tag = "R5/R6";
        end
      end else if (t < last) begin
        exp = 10'b1011110000; tag = "R7";
      end else begin
        exp = 10'b0100000000; tag = "R8";
      end
      if (busy) nbusy++;
      chk(outs() == exp, tag, t, 16'(outs()), 16'(exp));
      if (exp[7])
        chk(chain_sdi == tst_sdi && tst_sdo == chain_sdo, "R9", t,
            16'({chain_sdi, tst_sdo}), 16'({tst_sdi, chain_sdo}));
      else
        chk(chain_sdi == 1'b0 && tst_sdo == 1'b0, "R9", t,
            16'({chain_sdi, tst_sdo}), 16'd0);
      @(negedge clk);
    end
    #0.5;
    chk(outs() == 10'd0, "R8 idle after done", last + 1, 16'(outs()), 16'd0);
    chk(nbusy == exp_busy, poke ? "R2 run length" : "R7 run length", last,
        16'(nbusy), 16'(exp_busy));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_len = '0; cfg_pats = '0; cfg_dom_en = '0;
    tst_sdi = 1'b1; chain_sdo = 1'b1;
    #9;
    chk(outs() == 10'd0, "R1 in reset", 0, 16'(outs()), 16'd0);
    chk(chain_sdi == 1'b0 && tst_sdo == 1'b0, "R9 in reset", 0,
        16'({chain_sdi, tst_sdo}), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    chk(outs() == 10'd0, "R1 idle after reset", 0, 16'(outs()), 16'd0);
    for (int k = 0; k < NCFG; k++)
      run_cfg(TBL[k].len, TBL[k].pats, TBL[k].mask, int'(TBL[k].exp_busy), 1'b0);
    // R2: start and cfg changes mid-run do not disturb the run
    run_cfg(8'd3, 6'd2, 3'b011, 13, 1'b1);
    // R6: single-domain mask keeps hitting the same domain
    run_cfg(8'd2, 6'd3, 3'b100, 14, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule